// File: doc/BRIEF.md
# Supply-Monitor Reset Sequencer

This block turns a digitized supply indication into the system reset. A comparator flag says whether the supply sits above the trip point. A second flag says whether the supply is high enough for the logic to work at all. A timebase tick paces the release delay. The block drives an active-high reset and its exact complement, an active-low reset. It also drives a bus-inhibit level that the serial interface uses both to abandon a transfer in progress and to refuse new ones. Finally it runs a grant handshake that the memory controller must win before it may start a nonvolatile write.

Reset is held until the supply has stayed above the trip point for `DELAY_TICKS` timebase ticks without a break. Any dip during that window throws the count away. A watchdog request from elsewhere is ORed into both reset outputs without disturbing the sequence. Once a write has been granted, the grant stays up through a brown-out until the memory controller reports completion, so a write already under way always finishes. No new write is granted while the sequencer is not released.

The sequencer state machine has four states:
- `SEQ_OFF`: the supply is below the working minimum.
- `SEQ_HOLD`: the supply is below the trip point.
- `SEQ_DELAY`: the supply is above the trip point and the release count is running.
- `SEQ_RUN`: reset is released.

Its transitions are:
- Loss of the minimum flag goes to `SEQ_OFF` from any state, and overrides everything else.
- `SEQ_OFF` goes to `SEQ_HOLD` once the minimum flag is back.
- `SEQ_HOLD` goes to `SEQ_DELAY` when the trip flag rises.
- `SEQ_DELAY` goes back to `SEQ_HOLD` on a dip, and on to `SEQ_RUN` on the final counted tick.
- `SEQ_RUN` goes to `SEQ_HOLD` on a dip.

The write-grant machine has two states, `NV_IDLE` and `NV_GRANTED`:
- A request taken while released moves it to `NV_GRANTED`.
- A done pulse returns it to `NV_IDLE`.

Top module: `supply_reset_seq`

## Requirements
- R1: While `por_n` is low, `rst_o` is 1, `rst_n_o` is 0, `bus_inhibit_o` is 1 and `nv_grant_o` is 0, with no clock edge needed. The sequencer starts in `SEQ_OFF`.
- R2: Consider the clock edge that first samples `supply_ok_i`=1 and `supply_min_i`=1 in `SEQ_HOLD`. Counting from the edges after that one, reset is still asserted after DELAY_TICKS-1 sampled ticks. It is released right after the edge that samples the DELAY_TICKS-th tick, provided `supply_ok_i` stayed 1 throughout.
- R3: Any edge that samples `supply_ok_i`=0 leaves reset asserted right after that edge.
- R4: A dip of `supply_ok_i` during the delay, even a one-cycle dip just before the last tick, discards the count. A full DELAY_TICKS ticks are needed again after the supply recovers.
- R5: While `supply_min_i` is 0, reset stays asserted regardless of `supply_ok_i` and ticks. Ticks sampled outside the delay state have no effect on the count.
- R6: `wdt_req_i`=1 asserts `rst_o` in the same cycle, combinationally. Dropping it restores the sequencer's reset level, and the sequencer state is unaffected.
- R7: `rst_n_o` is always the exact complement of `rst_o`.
- R8: `bus_inhibit_o` is 1 exactly when the sequencer is not in `SEQ_RUN`. It does not follow `wdt_req_i`.
- R9: An edge that samples `nv_req_i`=1 while released and not granted sets `nv_grant_o` to 1 after that edge.
- R10: Once `nv_grant_o` is 1, it stays 1 through a supply drop or reset until an edge samples `nv_done_i`=1. It is 0 after that edge.
- R11: No grant is issued while the sequencer is not in `SEQ_RUN`. A request sampled then leaves `nv_grant_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| supply_ok_i | input | 1 | Supply above the trip point |
| supply_min_i | input | 1 | Supply above the working minimum |
| tick_i | input | 1 | Timebase tick, one cycle wide |
| wdt_req_i | input | 1 | Watchdog reset request |
| nv_req_i | input | 1 | Memory controller asks to start a nonvolatile write |
| nv_done_i | input | 1 | Granted nonvolatile write has completed |
| rst_n_o | output | 1 | System reset, active low |
| rst_o | output | 1 | System reset, active high |
| bus_inhibit_o | output | 1 | Abort current and refuse new serial transfers |
| nv_grant_o | output | 1 | Nonvolatile write may run |

## Verification
The hardest case to reach from the ports is a supply dip that lands on the final tick of the release window, or one cycle before it. Random supply toggling almost never hits that exact cycle. The bench therefore drives directed tick pulses up to DELAY_TICKS-1, drops `supply_ok_i` for a single cycle, and then proves that a full window is needed again. A second hard case is a brown-out that arrives while a write grant is held. It is forced by requesting a grant in the released state and then dropping the supply before the done pulse. Random phases with rare dips, minimum-supply losses, watchdog pulses and write handshakes are checked every cycle against a bench model.

// File: rtl/srs_pkg.sv
package srs_pkg;
    typedef enum logic [1:0] {
        SEQ_OFF   = 2'd0,
        SEQ_HOLD  = 2'd1,
        SEQ_DELAY = 2'd2,
        SEQ_RUN   = 2'd3
    } seq_state_e;

    typedef enum logic {
        NV_IDLE    = 1'b0,
        NV_GRANTED = 1'b1
    } nv_state_e;
endpackage

// File: rtl/srs_tick_counter.sv
module srs_tick_counter #(
    parameter int unsigned DELAY_TICKS = 200
) (
    input  logic clk,
    input  logic por_n,
    input  logic count_en_i,
    input  logic tick_i,
    output logic done_o
);
    localparam int unsigned CNT_W = (DELAY_TICKS > 1) ? $clog2(DELAY_TICKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q <= '0;
        end else if (!count_en_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    assign done_o = count_en_i && tick_i && (cnt_q == LAST);

    // R4: leaving the delay state discards the count
    assert_cnt_clear_R4: assert property (@(posedge clk) disable iff (!por_n)
        !count_en_i |=> cnt_q == '0);

    // R2: the count never passes the last tick position
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!por_n)
        cnt_q <= LAST);
endmodule

// File: rtl/srs_fsm.sv
module srs_fsm
    import srs_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic supply_ok_i,
    input  logic supply_min_i,
    input  logic done_i,
    output logic count_en_o,
    output logic rst_active_o,
    output logic released_o
);
    seq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= SEQ_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!supply_min_i) begin
            state_d = SEQ_OFF;
        end else begin
            unique case (state_q)
                SEQ_OFF:   state_d = SEQ_HOLD;
                SEQ_HOLD:  if (supply_ok_i) state_d = SEQ_DELAY;
                SEQ_DELAY: begin
                    if (!supply_ok_i) state_d = SEQ_HOLD;
                    else if (done_i)  state_d = SEQ_RUN;
                end
                SEQ_RUN:   if (!supply_ok_i) state_d = SEQ_HOLD;
            endcase
        end
    end

    always_comb begin
        count_en_o   = (state_q == SEQ_DELAY);
        released_o   = (state_q == SEQ_RUN);
        rst_active_o = !released_o;
    end

    // R3: a sampled dip keeps or puts reset active
    assert_dip_resets_R3: assert property (@(posedge clk) disable iff (!por_n)
        !supply_ok_i |=> rst_active_o);

    // R5: loss of the minimum supply lands in the off state
    assert_min_off_R5: assert property (@(posedge clk) disable iff (!por_n)
        !supply_min_i |=> state_q == SEQ_OFF);

    // R2: release happens only on the completing tick
    assert_release_gate_R2: assert property (@(posedge clk) disable iff (!por_n)
        (state_q != SEQ_RUN && !done_i) |=> state_q != SEQ_RUN);
endmodule

// File: rtl/srs_nv_gate.sv
module srs_nv_gate
    import srs_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic allow_i,
    input  logic nv_req_i,
    input  logic nv_done_i,
    output logic nv_grant_o
);
    nv_state_e g_q, g_d;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) g_q <= NV_IDLE;
        else        g_q <= g_d;
    end

    always_comb begin
        g_d = g_q;
        unique case (g_q)
            NV_IDLE:    if (nv_req_i && allow_i) g_d = NV_GRANTED;
            NV_GRANTED: if (nv_done_i)           g_d = NV_IDLE;
        endcase
    end

    always_comb nv_grant_o = (g_q == NV_GRANTED);

    // R10: a running write keeps its grant until done
    assert_grant_hold_R10: assert property (@(posedge clk) disable iff (!por_n)
        (nv_grant_o && !nv_done_i) |=> nv_grant_o);

    // R11: no new grant outside the released state
    assert_no_grant_R11: assert property (@(posedge clk) disable iff (!por_n)
        (!nv_grant_o && !allow_i) |=> !nv_grant_o);

    // R9: an accepted request is granted on the next cycle
    assert_grant_take_R9: assert property (@(posedge clk) disable iff (!por_n)
        (!nv_grant_o && allow_i && nv_req_i) |=> nv_grant_o);
endmodule

// File: rtl/supply_reset_seq.sv
module supply_reset_seq #(
    parameter int unsigned DELAY_TICKS = 200
) (
    input  logic clk,
    input  logic por_n,
    input  logic supply_ok_i,
    input  logic supply_min_i,
    input  logic tick_i,
    input  logic wdt_req_i,
    input  logic nv_req_i,
    input  logic nv_done_i,
    output logic rst_n_o,
    output logic rst_o,
    output logic bus_inhibit_o,
    output logic nv_grant_o
);
    logic count_en, done, rst_active, released;

    srs_tick_counter #(.DELAY_TICKS(DELAY_TICKS)) cnt_i (
        .clk        (clk),
        .por_n      (por_n),
        .count_en_i (count_en),
        .tick_i     (tick_i),
        .done_o     (done)
    );

    srs_fsm fsm_i (
        .clk          (clk),
        .por_n        (por_n),
        .supply_ok_i  (supply_ok_i),
        .supply_min_i (supply_min_i),
        .done_i       (done),
        .count_en_o   (count_en),
        .rst_active_o (rst_active),
        .released_o   (released)
    );

    srs_nv_gate nv_i (
        .clk        (clk),
        .por_n      (por_n),
        .allow_i    (released),
        .nv_req_i   (nv_req_i),
        .nv_done_i  (nv_done_i),
        .nv_grant_o (nv_grant_o)
    );

    always_comb begin
        rst_o         = rst_active || wdt_req_i;
        rst_n_o       = !rst_o;
        bus_inhibit_o = rst_active;
    end

    // R1: power-on reset holds every output in its safe state
    assert_por_safe_R1: assert property (@(posedge clk)
        !por_n |-> (rst_o && !rst_n_o && bus_inhibit_o && !nv_grant_o));

    // R8: the bus stays inhibited on the edge after a dip
    assert_inhibit_dip_R8: assert property (@(posedge clk) disable iff (!por_n)
        !supply_ok_i |=> bus_inhibit_o);
endmodule

// File: tb/supply_reset_seq_tb_top.sv
module supply_reset_seq_tb_top;
    localparam int unsigned N = 12;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic supply_ok = 1'b0, supply_min = 1'b0, tick = 1'b0;
    logic wdt = 1'b0, nv_req = 1'b0, nv_done = 1'b0;
    logic rst_n, rst, inhibit, grant;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit finished = 1'b0;

    // Bench model: 0 off, 1 hold, 2 delay, 3 run
    logic [1:0] m_st;
    int         m_cnt;
    bit         m_gnt;

    always #2 clk = ~clk;

    supply_reset_seq #(.DELAY_TICKS(N)) dut_i (
        .clk           (clk),
        .por_n         (por_n),
        .supply_ok_i   (supply_ok),
        .supply_min_i  (supply_min),
        .tick_i        (tick),
        .wdt_req_i     (wdt),
        .nv_req_i      (nv_req),
        .nv_done_i     (nv_done),
        .rst_n_o       (rst_n),
        .rst_o         (rst),
        .bus_inhibit_o (inhibit),
        .nv_grant_o    (grant)
    );

    function automatic logic exp_rst(logic [1:0] st, logic w);
        return (st != 2'd3) || w;
    endfunction

    function automatic logic exp_inhibit(logic [1:0] st);
        return st != 2'd3;
    endfunction

    always @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            m_st <= 2'd0; m_cnt <= 0; m_gnt <= 1'b0;
        end else begin
            if (m_gnt && nv_done) m_gnt <= 1'b0;
            else if (!m_gnt && nv_req && m_st == 2'd3) m_gnt <= 1'b1;
            if (!supply_min) begin
                m_st <= 2'd0; m_cnt <= 0;
            end else begin
                case (m_st)
                    2'd0: begin m_st <= 2'd1; m_cnt <= 0; end
                    2'd1: begin m_cnt <= 0; if (supply_ok) m_st <= 2'd2; end
                    2'd2: begin
                        if (!supply_ok) begin m_st <= 2'd1; m_cnt <= 0; end
                        else if (tick) begin
                            if (m_cnt == N - 1) begin m_st <= 2'd3; m_cnt <= 0; end
                            else m_cnt <= m_cnt + 1;
                        end
                    end
                    default: if (!supply_ok) m_st <= 2'd1;
                endcase
            end
        end
    end

    task automatic chk(string req, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Per-cycle comparison against the model
    always @(posedge clk) begin
        cycles++;
        #1;
        if (!finished) begin
            chk("R3 reset level", rst, exp_rst(m_st, wdt));
            chk("R7 complement", rst_n, ~rst);
            chk("R8 bus inhibit", inhibit, exp_inhibit(m_st));
            chk("R10 grant", grant, m_gnt);
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // R1: outputs safe during power-on reset, before any edge
        #1;
        chk("R1 rst", rst, 1'b1);
        chk("R1 rst_n", rst_n, 1'b0);
        chk("R1 inhibit", inhibit, 1'b1);
        chk("R1 grant", grant, 1'b0);
        idle(3);
        @(negedge clk) por_n = 1'b1;

        // R5: no minimum supply, trip flag high, ticks keep coming
        supply_ok = 1'b1;
        for (int i = 0; i < N + 3; i++) pulse_tick();
        chk("R5 held off", rst, 1'b1);

        // R2: exact release count
        @(negedge clk) begin supply_min = 1'b1; supply_ok = 1'b0; end
        idle(3);
        @(negedge clk) supply_ok = 1'b1;
        for (int i = 0; i < N - 1; i++) pulse_tick();
        chk("R2 before last tick", rst, 1'b1);
        pulse_tick();
        chk("R2 released", rst, 1'b0);
        chk("R8 inhibit off", inhibit, 1'b0);

        // R6: watchdog ORs in without altering the sequence
        @(negedge clk) wdt = 1'b1;
        #1 chk("R6 wdt asserts", rst, 1'b1);
        chk("R8 inhibit ignores wdt", inhibit, 1'b0);
        idle(2);
        @(negedge clk) wdt = 1'b0;
        #1 chk("R6 wdt removed", rst, 1'b0);

        // R9 and R10: grant, then brown-out while granted
        @(negedge clk) nv_req = 1'b1;
        @(negedge clk) nv_req = 1'b0;
        chk("R9 grant taken", grant, 1'b1);
        @(negedge clk) supply_ok = 1'b0;
        idle(3);
        chk("R3 brown-out", rst, 1'b1);
        chk("R10 grant survives", grant, 1'b1);
        @(negedge clk) nv_done = 1'b1;
        @(negedge clk) nv_done = 1'b0;
        chk("R10 grant ends", grant, 1'b0);
        // R11: request while held in reset
        @(negedge clk) nv_req = 1'b1;
        idle(2);
        @(negedge clk) nv_req = 1'b0;
        chk("R11 no grant", grant, 1'b0);

        // R4: one-cycle dip right before the last tick
        @(negedge clk) supply_ok = 1'b1;
        for (int i = 0; i < N - 1; i++) pulse_tick();
        @(negedge clk) supply_ok = 1'b0;
        @(negedge clk) supply_ok = 1'b1;
        pulse_tick();
        chk("R4 count discarded", rst, 1'b1);
        for (int i = 0; i < N - 2; i++) pulse_tick();
        chk("R4 still held", rst, 1'b1);
        pulse_tick();
        chk("R4 released after full window", rst, 1'b0);

        // R1: power-on reset mid-run
        @(negedge clk) por_n = 1'b0;
        #1 chk("R1 async reset", rst, 1'b1);
        idle(2);
        @(negedge clk) por_n = 1'b1;

        // Random phase checked against the model
        for (int c = 0; c < 6000; c++) begin
            @(negedge clk);
            tick    = ($urandom_range(3) == 0);
            if ($urandom_range(149) == 0) supply_ok = ~supply_ok;
            supply_min = ($urandom_range(999) != 0);
            wdt     = ($urandom_range(49) == 0);
            nv_req  = ($urandom_range(5) == 0);
            nv_done = ($urandom_range(7) == 0);
        end
        idle(2);
        summary();
    end

    initial begin
        #400000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end
endmodule